// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fixed 125 MHz reference clock into the oversampling clock enable of one UART channel. It first passes the clock through an optional divide-by-4 prescaler. A divisor then counts down the prescaled enables. The divisor has a 16-bit integer part and a 4-bit fraction in steps of 1/16. The block meets the fraction by lengthening some periods by one prescaled unit, following a fixed 16-period pattern. For example, 9600 baud at 16x needs a divisor of about 813.80, which is 813 plus 13/16. A divisor of 312.5 gives exactly 25000 baud.

Each period ends with a one-cycle `sample_tick`. A second output, `bit_tick`, fires on every 16th, 8th or 4th sample tick, depending on the sampling-ratio selects, and so marks one serial bit time. For the same divisor, the 8x ratio doubles the data rate and 4x quadruples it. Software loads the divisor through a byte-wide write port. Any write to a divisor byte restarts the prescaler, the divider and the bit counter from a clean state.

Top module: `fbrg_top`

## Requirements
- R1: Reset leaves the integer low byte at 0x01, the integer high byte at 0x00 and the fraction at 0x00. `sample_tick` is low while `rst_n` is low. With the prescaler off, `sample_tick` is high on every clock edge from the first edge after reset is released.
- R2: Let N be the integer divisor, with the high byte written at address 1 and the low byte at address 0. With the prescaler off and a fraction of zero, consecutive sample ticks are exactly N clocks apart.
- R3: An integer divisor of zero behaves exactly like a divisor of one.
- R4: With `prescale_sel` high, the prescaled unit is 4 clocks instead of 1, so every period in R2 and R5 becomes four times as long.
- R5: The fraction F is bits 3:0 of the byte written at address 2; bits 7:4 are ignored. Period k after a restart (k = 1..16, then repeating) lasts unit*(N + s), where s = floor(k*F/16) - floor((k-1)*F/16). So exactly F of every 16 periods are one unit longer.
- R6: A write to address 0, 1 or 2 on clock edge W restarts the block. No sample tick is registered on edges W+1 to W+unit*N. The first sample tick after the restart is registered on edge W+unit*N+1.
- R7: `bit_tick` fires on every R-th sample tick counted from a restart. R is 16 when both selects are low, 8 when only `samp8_sel` is high, and 4 whenever `samp4_sel` is high, whatever the value of `samp8_sel`.
- R8: `bit_tick` is never high in a cycle where `sample_tick` is low.
- R9: A write to address 3 changes nothing: the tick timing carries on as if the write had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Divisor register write strobe |
| wr_addr | input | 2 | 0 integer low, 1 integer high, 2 fraction, 3 unused |
| wr_data | input | 8 | Write data |
| prescale_sel | input | 1 | 1 selects divide-by-4 ahead of the divisor |
| samp8_sel | input | 1 | Selects 8x oversampling |
| samp4_sel | input | 1 | Selects 4x oversampling; takes precedence over samp8_sel |
| sample_tick | output | 1 | One-cycle oversampling enable |
| bit_tick | output | 1 | One-cycle enable once per bit time |

## Verification
The sharpest collision is a divisor write whose restart lands in the very cycle in which the running divider would end its period. The bench aligns a write to one such terminal count on a divisor of 5. It then requires that no tick is registered on the following edge and that the first tick comes exactly N+1 clocks after the write. A second collision is every R-th sample tick, where both outputs must rise together. The bench judges this by walking 2*R sample ticks in each ratio setting, including both selects high. Fractional patterns are compared period by period against the floor formula over a full 16-period cycle.

// File: rtl/fbrg_pkg.sv
package fbrg_pkg;

   // oversampling ratio selected by the channel
   typedef enum logic [1:0] {
      OSR_16 = 2'd0,
      OSR_8  = 2'd1,
      OSR_4  = 2'd2
   } osr_e;

   localparam int MAX_OSR = 16;

   function automatic int unsigned osr_ratio(osr_e m);
      case (m)
         OSR_8:   return 8;
         OSR_4:   return 4;
         default: return MAX_OSR;
      endcase
   endfunction

endpackage

// File: rtl/fbrg_regs.sv
module fbrg_regs #(
   parameter int REG_W  = 8,
   parameter int INT_W  = 16,
   parameter int FRAC_W = 4,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [INT_W-1:0]  div_int,
   output logic [FRAC_W-1:0] div_frac,
   output logic              restart
);
   localparam int NBYTES = INT_W / REG_W;
   localparam logic [ADDR_W-1:0] FRAC_ADDR = ADDR_W'(NBYTES);

   if (INT_W % REG_W != 0) begin : g_bad_int
      $error("integer width must be a whole number of register bytes");
   end
   if (FRAC_W > REG_W) begin : g_bad_frac
      $error("fraction wider than a register byte");
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      localparam logic [REG_W-1:0] RST_V = (b == 0) ? REG_W'(1) : '0;
      logic [REG_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= RST_V;
         else if (wr_en && wr_addr == ADDR_W'(b))
            q <= wr_data;
      end
      assign div_int[b*REG_W +: REG_W] = q;
   end

   logic [FRAC_W-1:0] frac_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         frac_q <= '0;
      else if (wr_en && wr_addr == FRAC_ADDR)
         frac_q <= wr_data[FRAC_W-1:0];
   end
   assign div_frac = frac_q;

   // restart is seen one cycle after the write, when the new value is stored
   always_ff @(posedge clk) begin
      if (!rst_n)
         restart <= 1'b0;
      else
         restart <= wr_en && (wr_addr <= FRAC_ADDR);
   end

endmodule

// File: rtl/fbrg_prescale.sv
module fbrg_prescale #(
   parameter int PRE_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic sel,
   output logic pre_en
);
   if (PRE_DIV < 1) begin : g_bad_div
      $error("prescale ratio must be at least one");
   end

   if (PRE_DIV == 1) begin : g_none
      assign pre_en = 1'b1;
   end else begin : g_div
      localparam int PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] pcnt;

      always_ff @(posedge clk) begin
         if (!rst_n || restart)
            pcnt <= '0;
         else if (pcnt == LAST)
            pcnt <= '0;
         else
            pcnt <= pcnt + 1'b1;
      end

      assign pre_en = !sel || (pcnt == LAST);

      // R4
      pre_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && pre_en && !restart) |=> (!pre_en || !sel));
   end

endmodule

// File: rtl/fbrg_divider.sv
module fbrg_divider #(
   parameter int INT_W  = 16,
   parameter int FRAC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              pre_en,
   input  logic [INT_W-1:0]  div_int,
   input  logic [FRAC_W-1:0] div_frac,
   output logic              fire
);
   localparam int CW = INT_W + 1;

   logic [CW-1:0]     cnt;
   logic [CW-1:0]     n_eff;
   logic [FRAC_W-1:0] acc;
   logic [FRAC_W-1:0] acc_sum;
   logic              carry;

   always_comb begin
      n_eff = (div_int == '0) ? CW'(1) : CW'(div_int);
      {carry, acc_sum} = {1'b0, acc} + {1'b0, div_frac};
      fire = pre_en && (cnt == CW'(1)) && !restart;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= CW'(1);
         acc <= '0;
      end else if (restart) begin
         cnt <= n_eff;
         acc <= div_frac;
      end else if (pre_en) begin
         if (cnt == CW'(1)) begin
            cnt <= n_eff + CW'(carry);
            acc <= acc_sum;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !restart |-> (cnt != '0 && cnt <= n_eff + CW'(1)));

endmodule

// File: rtl/fbrg_bitcnt.sv
module fbrg_bitcnt
   import fbrg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic tick,
   input  osr_e mode,
   output logic bit_tick
);
   localparam int BW = $clog2(MAX_OSR);

   logic [BW-1:0] bcnt;
   logic [BW-1:0] last;
   logic          wrap;

   always_comb begin
      last = BW'(osr_ratio(mode) - 1);
      wrap = (bcnt >= last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || restart)
         bcnt <= '0;
      else if (tick)
         bcnt <= wrap ? '0 : bcnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         bit_tick <= 1'b0;
      else
         bit_tick <= tick && wrap;
   end

endmodule

// File: rtl/fbrg_top.sv
module fbrg_top
   import fbrg_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int INT_W   = 16,
   parameter int FRAC_W  = 4,
   parameter int PRE_DIV = 4,
   parameter int ADDR_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              prescale_sel,
   input  logic              samp8_sel,
   input  logic              samp4_sel,
   output logic              sample_tick,
   output logic              bit_tick
);
   localparam int NBYTES = INT_W / REG_W;

   if ((1 << ADDR_W) < NBYTES + 1) begin : g_bad_addr
      $error("address width too narrow for the divisor registers");
   end

   logic [INT_W-1:0]  div_int;
   logic [FRAC_W-1:0] div_frac;
   logic              restart;
   logic              pre_en;
   logic              fire;
   osr_e              mode;

   assign mode = samp4_sel ? OSR_4 : (samp8_sel ? OSR_8 : OSR_16);

   fbrg_regs #(
      .REG_W(REG_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .ADDR_W(ADDR_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .div_int(div_int), .div_frac(div_frac),
      .restart(restart)
   );

   fbrg_prescale #(.PRE_DIV(PRE_DIV)) i_pre (
      .clk(clk), .rst_n(rst_n), .restart(restart), .sel(prescale_sel),
      .pre_en(pre_en)
   );

   fbrg_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_div (
      .clk(clk), .rst_n(rst_n), .restart(restart), .pre_en(pre_en),
      .div_int(div_int), .div_frac(div_frac), .fire(fire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         sample_tick <= 1'b0;
      else
         sample_tick <= fire;
   end

   fbrg_bitcnt i_bit (
      .clk(clk), .rst_n(rst_n), .restart(restart), .tick(fire),
      .mode(mode), .bit_tick(bit_tick)
   );

   // R6
   wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr <= ADDR_W'(NBYTES)) |=> ##1 !sample_tick);

   // R8
   bit_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |-> sample_tick);

endmodule

// File: tb/test_fbrg_top.sv
module test_fbrg_top;
   localparam int CLK_P = 8;
   localparam int NV = 8;
   // {prescale, int high, int low, fraction register}
   localparam logic [24:0] VEC [NV] = '{
      {1'b0, 8'h00, 8'h05, 8'h00},
      {1'b0, 8'h01, 8'h02, 8'h00},
      {1'b0, 8'h00, 8'h00, 8'h00},
      {1'b1, 8'h00, 8'h03, 8'h00},
      {1'b0, 8'h00, 8'h07, 8'h08},
      {1'b0, 8'h00, 8'h04, 8'hA5},
      {1'b1, 8'h00, 8'h02, 8'h0F},
      {1'b0, 8'h00, 8'h01, 8'h01}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       prescale_sel = 1'b0;
   logic       samp8_sel = 1'b0;
   logic       samp4_sel = 1'b0;
   logic       sample_tick;
   logic       bit_tick;

   int total = 0;
   int bad = 0;

   always #(CLK_P/2) clk = ~clk;

   fbrg_top i_fbrg_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .prescale_sel(prescale_sel), .samp8_sel(samp8_sel),
      .samp4_sel(samp4_sel), .sample_tick(sample_tick), .bit_tick(bit_tick)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_tick(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sample_tick && n < 100000);
   endtask

   function automatic int stretch(input int k, input int f);
      return (k * f) / 16 - ((k - 1) * f) / 16;
   endfunction

   initial begin
      #(CLK_P * 150000);
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      // R1 reset state
      repeat (3) begin
         @(negedge clk);
         chk(sample_tick == 1'b0, "R1", sample_tick, 0);
      end
      rst_n = 1'b1;
      repeat (4) begin
         @(negedge clk);
         chk(sample_tick == 1'b1, "R1", sample_tick, 1);
      end

      // vector table: R2 R3 R4 R5 R6
      for (int v = 0; v < NV; v++) begin
         int unit, ne, f;
         string tag;
         prescale_sel = VEC[v][24];
         unit = VEC[v][24] ? 4 : 1;
         ne = int'(VEC[v][23:8]);
         if (ne == 0) ne = 1;
         f = int'(VEC[v][3:0]);
         tag = (f != 0) ? "R5" : (VEC[v][24] ? "R4" :
               (VEC[v][23:8] == 16'd0) ? "R3" : "R2");
         wr(2'd0, VEC[v][15:8]);
         wr(2'd1, VEC[v][23:16]);
         wr(2'd2, VEC[v][7:0]);
         wait_tick(n);
         chk(n == unit * ne + 1, "R6", n, unit * ne + 1);
         for (int k = 2; k <= 16; k++) begin
            wait_tick(n);
            chk(n == unit * (ne + stretch(k, f)), tag, n, unit * (ne + stretch(k, f)));
         end
      end

      // R6 collision: restart lands on the terminal count of N=5
      prescale_sel = 1'b0;
      wr(2'd1, 8'h00);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'h05);
      wait_tick(n);
      repeat (3) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h05;
      @(negedge clk);
      wr_en = 1'b0;
      wait_tick(n);
      chk(n == 6, "R6", n, 6);

      // R9 write to address 3 leaves timing untouched
      wait_tick(n);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h00;
      n = 0;
      do begin
         @(negedge clk);
         wr_en = 1'b0;
         n++;
      end while (!sample_tick && n < 100);
      chk(n == 5, "R9", n, 5);
      wait_tick(n);
      chk(n == 5, "R9", n, 5);

      // R7 R8 bit tick per ratio, including both selects high
      for (int m = 0; m < 4; m++) begin
         int osr, i;
         samp8_sel = (m == 1 || m == 3);
         samp4_sel = (m >= 2);
         osr = (m == 0) ? 16 : ((m == 1) ? 8 : 4);
         wr(2'd0, 8'h02);
         i = 0;
         while (i < 2 * osr) begin
            @(negedge clk);
            if (bit_tick && !sample_tick)
               chk(1'b0, "R8", bit_tick, 0);
            if (sample_tick) begin
               i++;
               chk(bit_tick == (i % osr == 0), "R7", bit_tick, int'(i % osr == 0));
            end
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule